// File: doc/BRIEF.md
# Register-Exchange Viterbi Decoder

This block decodes a hard-decision stream of a rate-1/2 convolutional code with constraint length 5 (16 trellis states). Each accepted input is a 2-bit coded symbol. Each step updates all path metrics and all survivor paths together. Decoded information bits leave at a fixed depth of 32 stages, and no traceback pass is needed.

The trellis is indexed so that present states 2j and 2j+1 feed exactly the next states j and j+8. This gives eight independent add-compare-select butterflies that work side by side. Each state owns a 32-bit survivor register. When a next state picks its predecessor, it takes that predecessor's survivor shifted by one place, with the new decision bit appended. The oldest bit of the survivor owned by the best state is the decoded output. Path metrics are 8 bits wide and are renormalised when they grow large. A synchronous clear restarts decoding from state 0.

A small sequencer counts the stages after each clear. Its states are ST_EMPTY (no symbol accepted since reset or clear), ST_FILL (fewer than 32 symbols accepted) and ST_STREAM (one decoded bit per accepted symbol). Its transitions are:
- ST_EMPTY → ST_FILL on the first accepted symbol.
- ST_FILL → ST_STREAM on the 32nd accepted symbol.
- Any state → ST_EMPTY on clear.

Top module: `vit_re_decoder`

## Requirements
- R1: The encoder convention is as follows. The state is the last four input bits, with state bit 3 the most recent. The encoder register is {input, state}. sym_in[1] is the parity under generator 23 octal and sym_in[0] the parity under generator 35 octal. The next state is {input, state[3:1]}, starting from state 0. For an error-free stream, bit_out reproduces the encoder input bits in order.
- R2: bit_valid first rises in the cycle after the clock edge that accepts the 32nd symbol since reset or clear. After that it is high for exactly one cycle after each accepted symbol. This leaves exactly 31 accepted bits undelivered at the end of a stream.
- R3: In a cycle where sym_valid is low, path metrics and survivors do not change, sym_in is ignored, and bit_valid is low in the next cycle. Idle gaps inside a stream do not change the decoded bits.
- R4: A single flipped coded bit is corrected, as long as at least 40 symbols separate it from the next flipped bit.
- R5: Path metrics never overflow. Whenever the smallest new metric reaches 128 or more, it is subtracted from all metrics in the same step. Decoding stays correct over streams that accumulate more than 128 channel errors.
- R6: clr restarts decoding. While clr is high, any symbol presented is discarded and bit_valid is low in the next cycle. Decoding resumes from encoder state 0 with a fresh 32-symbol fill.
- R7: After reset, bit_valid is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| clr | input | 1 | Synchronous restart of metrics, survivors and sequencer |
| sym_valid | input | 1 | sym_in carries a symbol this cycle |
| sym_in | input | 2 | Hard coded symbol: bit 1 from generator 23, bit 0 from generator 35 (octal) |
| bit_valid | output | 1 | bit_out carries a decoded bit |
| bit_out | output | 1 | Decoded information bit |

## Verification
Each decoded bit is due one cycle after the edge that accepts the symbol 31 positions after its own. The first bit is due one cycle after the 32nd accepted symbol. A monitor samples shortly after every rising edge and counts accepted symbols since the last clear. From that count it predicts whether bit_valid must be high in that cycle. Whenever a bit appears, the monitor pops the oldest expected bit from the driver's queue. At the end of each stream, exactly 31 queued bits must remain, which pins the latency from both ends.

// File: rtl/vit_pkg.sv
package vit_pkg;

    localparam int unsigned VIT_K   = 5;
    localparam int unsigned VIT_MEM = VIT_K - 1;
    localparam int unsigned VIT_NS  = 1 << VIT_MEM;
    localparam int unsigned VIT_NB  = VIT_NS / 2;

    localparam logic [VIT_K-1:0] VIT_GEN_A = 5'o23;
    localparam logic [VIT_K-1:0] VIT_GEN_B = 5'o35;

    typedef enum logic [1:0] {
        ST_EMPTY  = 2'd0,
        ST_FILL   = 2'd1,
        ST_STREAM = 2'd2
    } vit_phase_e;

    // Coded pair produced by the encoder when input bit b enters state st.
    function automatic logic [1:0] vit_code_sym(input logic b, input logic [VIT_MEM-1:0] st);
        logic [VIT_K-1:0] regv;
        regv = {b, st};
        return {^(regv & VIT_GEN_A), ^(regv & VIT_GEN_B)};
    endfunction

    // Hamming distance between two 2-bit symbols.
    function automatic logic [1:0] vit_ham2(input logic [1:0] a, input logic [1:0] b);
        logic [1:0] d;
        d = a ^ b;
        return {1'b0, d[1]} + {1'b0, d[0]};
    endfunction

endpackage

// File: rtl/vit_seq_ctrl.sv
module vit_seq_ctrl
    import vit_pkg::*;
#(
    parameter int unsigned DEPTH = 32
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       clr,
    input  logic       sym_valid,
    output logic       emit,
    output vit_phase_e phase
);

    localparam int unsigned CW = $clog2(DEPTH + 1);
    localparam logic [CW-1:0] LAST_FILL = CW'(DEPTH - 1);

    vit_phase_e    state_q, state_d;
    logic [CW-1:0] fill_q;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_EMPTY;
        end else begin
            state_q <= state_d;
        end
    end

    // Fill counter: symbols accepted since the last restart, until streaming
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            fill_q <= '0;
        end else if (clr) begin
            fill_q <= '0;
        end else if (sym_valid && (state_q != ST_STREAM)) begin
            fill_q <= fill_q + 1'b1;
        end
    end

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_EMPTY: begin
                if (clr) begin
                    state_d = ST_EMPTY;
                end else if (sym_valid) begin
                    state_d = ST_FILL;
                end
            end
            ST_FILL: begin
                if (clr) begin
                    state_d = ST_EMPTY;
                end else if (sym_valid && (fill_q == LAST_FILL)) begin
                    state_d = ST_STREAM;
                end
            end
            ST_STREAM: begin
                if (clr) begin
                    state_d = ST_EMPTY;
                end
            end
            default: state_d = ST_EMPTY;
        endcase
    end

    // Outputs
    always_comb begin
        emit  = 1'b0;
        phase = state_q;
        unique case (state_q)
            ST_EMPTY:  emit = 1'b0;
            ST_FILL:   emit = sym_valid && !clr && (fill_q == LAST_FILL);
            ST_STREAM: emit = sym_valid && !clr;
            default:   emit = 1'b0;
        endcase
    end

endmodule

// File: rtl/vit_acs_bfly.sv
module vit_acs_bfly
    import vit_pkg::*;
#(
    parameter int unsigned J     = 0,
    parameter int unsigned PM_W  = 8,
    parameter int unsigned DEPTH = 32
) (
    input  logic [1:0]       rx_sym,
    input  logic [PM_W-1:0]  pm_even,
    input  logic [PM_W-1:0]  pm_odd,
    input  logic [DEPTH-1:0] sv_even,
    input  logic [DEPTH-1:0] sv_odd,
    output logic [PM_W:0]    pm_low,
    output logic [PM_W:0]    pm_high,
    output logic [DEPTH-1:0] sv_low,
    output logic [DEPTH-1:0] sv_high
);

    localparam logic [VIT_MEM-1:0] ST_EVEN = VIT_MEM'(2 * J);
    localparam logic [VIT_MEM-1:0] ST_ODD  = VIT_MEM'(2 * J + 1);

    logic [PM_W:0] cand [2][2];
    logic [1:0]    take_odd;
    logic [PM_W:0] best [2];
    logic [DEPTH-1:0] path [2];

    // One compare-select per decision bit b: next state J + b*NS/2
    for (genvar b = 0; b < 2; b++) begin : g_dec
        always_comb begin
            cand[b][0] = {1'b0, pm_even} +
                         (PM_W+1)'(vit_ham2(rx_sym, vit_code_sym(b[0], ST_EVEN)));
            cand[b][1] = {1'b0, pm_odd} +
                         (PM_W+1)'(vit_ham2(rx_sym, vit_code_sym(b[0], ST_ODD)));
            // ties keep the lower-numbered predecessor
            take_odd[b] = cand[b][1] < cand[b][0];
            best[b]     = take_odd[b] ? cand[b][1] : cand[b][0];
            path[b]     = take_odd[b] ? {sv_odd[DEPTH-2:0], b[0]}
                                      : {sv_even[DEPTH-2:0], b[0]};
        end
    end

    assign pm_low  = best[0];
    assign pm_high = best[1];
    assign sv_low  = path[0];
    assign sv_high = path[1];

endmodule

// File: rtl/vit_pm_min.sv
module vit_pm_min #(
    parameter int unsigned N  = 16,
    parameter int unsigned W  = 9,
    parameter int unsigned IW = $clog2(N)
) (
    input  logic [N*W-1:0] vals,
    output logic [W-1:0]   min_val,
    output logic [IW-1:0]  min_idx
);

    // Strict compare: the lowest index wins a tie
    always_comb begin
        min_val = vals[W-1:0];
        min_idx = '0;
        for (int i = 1; i < N; i++) begin
            if (vals[i*W +: W] < min_val) begin
                min_val = vals[i*W +: W];
                min_idx = IW'(i);
            end
        end
    end

endmodule

// File: rtl/vit_re_decoder.sv
module vit_re_decoder
    import vit_pkg::*;
#(
    parameter int unsigned DEPTH   = 32,
    parameter int unsigned PM_W    = 8,
    parameter int unsigned INIT_PM = 64
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       clr,
    input  logic       sym_valid,
    input  logic [1:0] sym_in,
    output logic       bit_valid,
    output logic       bit_out
);

    localparam int unsigned NS  = VIT_NS;
    localparam int unsigned NB  = VIT_NB;
    localparam int unsigned IW  = $clog2(NS);
    localparam int unsigned RW  = PM_W + 1;
    localparam logic [RW-1:0] NORM_AT = RW'(1 << (PM_W - 1));

    logic [PM_W-1:0]  pm_q   [NS];
    logic [DEPTH-1:0] sv_q   [NS];
    logic [RW-1:0]    pm_raw [NS];
    logic [DEPTH-1:0] sv_nx  [NS];
    logic [PM_W-1:0]  pm_nx  [NS];
    logic [NS*RW-1:0] raw_flat;
    logic [NS*PM_W-1:0] pm_flat;
    logic [RW-1:0]    raw_min;
    logic [IW-1:0]    best_st;
    logic             do_norm;
    logic             emit;
    vit_phase_e       phase;

    vit_seq_ctrl #(.DEPTH(DEPTH)) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .clr       (clr),
        .sym_valid (sym_valid),
        .emit      (emit),
        .phase     (phase)
    );

    // Eight butterflies: present {2j, 2j+1} -> next {j, j+NB}
    for (genvar j = 0; j < NB; j++) begin : g_bfly
        vit_acs_bfly #(.J(j), .PM_W(PM_W), .DEPTH(DEPTH)) u_bfly (
            .rx_sym  (sym_in),
            .pm_even (pm_q[2*j]),
            .pm_odd  (pm_q[2*j+1]),
            .sv_even (sv_q[2*j]),
            .sv_odd  (sv_q[2*j+1]),
            .pm_low  (pm_raw[j]),
            .pm_high (pm_raw[j+NB]),
            .sv_low  (sv_nx[j]),
            .sv_high (sv_nx[j+NB])
        );
    end

    for (genvar s = 0; s < NS; s++) begin : g_flat
        assign raw_flat[s*RW +: RW]     = pm_raw[s];
        assign pm_flat[s*PM_W +: PM_W]  = pm_q[s];
    end

    vit_pm_min #(.N(NS), .W(RW), .IW(IW)) u_min (
        .vals    (raw_flat),
        .min_val (raw_min),
        .min_idx (best_st)
    );

    // Renormalise in the same step once the best metric reaches half range
    assign do_norm = raw_min >= NORM_AT;

    for (genvar s = 0; s < NS; s++) begin : g_norm
        assign pm_nx[s] = do_norm ? PM_W'(pm_raw[s] - raw_min) : PM_W'(pm_raw[s]);
    end

    // Metric and survivor registers
    for (genvar s = 0; s < NS; s++) begin : g_state
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                pm_q[s] <= (s == 0) ? '0 : PM_W'(INIT_PM);
                sv_q[s] <= '0;
            end else if (clr) begin
                pm_q[s] <= (s == 0) ? '0 : PM_W'(INIT_PM);
                sv_q[s] <= '0;
            end else if (sym_valid) begin
                pm_q[s] <= pm_nx[s];
                sv_q[s] <= sv_nx[s];
            end
        end
    end

    // Output register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bit_valid <= 1'b0;
            bit_out   <= 1'b0;
        end else begin
            bit_valid <= emit;
            if (emit) begin
                bit_out <= sv_nx[best_st][DEPTH-1];
            end
        end
    end

endmodule

// File: rtl/vit_re_decoder_chk.sv
module vit_re_decoder_chk #(
    parameter int unsigned DEPTH = 32,
    parameter int unsigned PM_W  = 8,
    parameter int unsigned NS    = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             clr,
    input logic             sym_valid,
    input logic             bit_valid,
    input logic [NS*PM_W-1:0] pm_flat
);

    localparam int unsigned CW = $clog2(DEPTH + 1);

    logic [CW-1:0] acc_cnt;
    logic          some_low;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            acc_cnt <= '0;
        end else if (clr) begin
            acc_cnt <= '0;
        end else if (sym_valid && (acc_cnt != CW'(DEPTH))) begin
            acc_cnt <= acc_cnt + 1'b1;
        end
    end

    always_comb begin
        some_low = 1'b0;
        for (int s = 0; s < NS; s++) begin
            if (pm_flat[s*PM_W +: PM_W] < PM_W'(1 << (PM_W - 1))) begin
                some_low = 1'b1;
            end
        end
    end

    // R2
    out_follows_input_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bit_valid |-> $past(sym_valid && !clr));

    // R2
    no_early_output_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bit_valid |-> (acc_cnt == CW'(DEPTH)));

    // R3
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!sym_valid && !clr) |=> $stable(pm_flat));

    // R3
    idle_no_output_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !sym_valid |=> !bit_valid);

    // R5
    no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        some_low);

    // R6
    clear_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> !bit_valid);

endmodule

bind vit_re_decoder vit_re_decoder_chk #(
    .DEPTH (DEPTH),
    .PM_W  (PM_W),
    .NS    (NS)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .clr       (clr),
    .sym_valid (sym_valid),
    .bit_valid (bit_valid),
    .pm_flat   (pm_flat)
);

// File: tb/vit_re_decoder_tb.sv
module vit_re_decoder_tb;

    localparam int DEPTH = 32;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       clr = 1'b0;
    logic       sym_valid = 1'b0;
    logic [1:0] sym_in = 2'b00;
    logic       bit_valid;
    logic       bit_out;

    int   n_chk = 0;
    int   n_bad = 0;
    bit   done = 0;
    int   nsym = 0;
    string cur_req = "R1";
    logic [3:0] enc_st = '0;
    bit   exp_q [$];

    vit_re_decoder u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .clr       (clr),
        .sym_valid (sym_valid),
        .sym_in    (sym_in),
        .bit_valid (bit_valid),
        .bit_out   (bit_out)
    );

    always #2.5 clk = ~clk;

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    // Driver: encode one bit, optionally corrupt, push the expected output
    task automatic send(input bit b, input logic [1:0] flip, input int gap);
        logic [4:0] regv;
        for (int i = 0; i < gap; i++) begin
            @(negedge clk);
            sym_valid = 1'b0;
            sym_in    = 2'($urandom);
        end
        regv = {b, enc_st};
        @(negedge clk);
        sym_in    = {^(regv & 5'o23), ^(regv & 5'o35)} ^ flip;
        sym_valid = 1'b1;
        enc_st    = {b, enc_st[3:1]};
        exp_q.push_back(b);
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            sym_valid = 1'b0;
        end
    endtask

    task automatic restart(input bit with_sym);
        @(negedge clk);
        clr       = 1'b1;
        sym_valid = with_sym;
        sym_in    = 2'b11;
        exp_q.delete();
        enc_st    = '0;
        @(negedge clk);
        clr       = 1'b0;
        sym_valid = 1'b0;
    endtask

    task automatic end_stream(input int sent);
        idle(4);
        // R2: exactly 31 bits stay undelivered
        check(exp_q.size() == ((sent >= DEPTH - 1) ? DEPTH - 1 : sent),
              "R2", exp_q.size(), DEPTH - 1);
    endtask

    // Monitor: cadence and scoreboard, sampled just after each rising edge
    always @(posedge clk) begin
        bit exp_v;
        bit e;
        #1;
        if (!rst_n) begin
            nsym = 0;
        end else begin
            if (clr) nsym = 0;
            else if (sym_valid) nsym++;
            exp_v = sym_valid && !clr && (nsym >= DEPTH);
            if (exp_v || bit_valid) begin
                check(bit_valid == exp_v, "R2", bit_valid, exp_v);
            end
            if (bit_valid) begin
                if (exp_q.size() == 0) begin
                    check(1'b0, cur_req, bit_out, -1);
                end else begin
                    e = exp_q.pop_front();
                    check(bit_out == e, cur_req, bit_out, e);
                end
            end
        end
    end

    initial begin
        #(200000 * 5);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R7: reset state
        check(bit_valid == 1'b0, "R7", bit_valid, 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(bit_valid == 1'b0, "R7", bit_valid, 0);

        // R1: random error-free stream
        cur_req = "R1";
        for (int i = 0; i < 200; i++) send(1'($urandom), 2'b00, 0);
        end_stream(200);

        // R1: structured patterns (ones, alternating, zeros)
        restart(1'b0);
        for (int i = 0; i < 60; i++) send(1'b1, 2'b00, 0);
        for (int i = 0; i < 60; i++) send(1'(i), 2'b00, 0);
        for (int i = 0; i < 60; i++) send(1'b0, 2'b00, 0);
        end_stream(180);

        // R3: idle gaps with garbage on sym_in
        restart(1'b0);
        cur_req = "R3";
        for (int i = 0; i < 300; i++) send(1'($urandom), 2'b00, int'($urandom % 4));
        idle(20);
        check(bit_valid == 1'b0, "R3", bit_valid, 0);
        end_stream(300);

        // R4: isolated channel errors
        restart(1'b0);
        cur_req = "R4";
        for (int i = 0; i < 600; i++)
            send(1'($urandom), (i % 40 == 20) ? 2'(1 + (i / 40) % 3) : 2'b00, 0);
        end_stream(600);

        // R6: clear mid-stream, with a symbol presented during clear
        cur_req = "R6";
        for (int i = 0; i < 50; i++) send(1'($urandom), 2'b00, 0);
        restart(1'b1);
        check(bit_valid == 1'b0, "R6", bit_valid, 0);
        for (int i = 0; i < 100; i++) send(1'($urandom), 2'b00, 0);
        end_stream(100);

        // R5: many errors, metrics must renormalise
        restart(1'b0);
        cur_req = "R5";
        for (int i = 0; i < 6000; i++)
            send(1'($urandom), (i % 40 == 7) ? 2'b01 : 2'b00, 0);
        end_stream(6000);

        done = 1;
        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

endmodule